// File: doc/BRIEF.md
# Push-Button Memory Exerciser

This block turns one push button, a 4-bit switch bank and an 8-LED display into a test driver for the host side of an SDRAM controller. The button is synchronised and edge-detected. Each press is then classified by click count. One click that gets no follow-up press inside a programmable gap window becomes a write request. A second press inside that window becomes a read request. Each request raises the matching enable towards the controller. The enable is dropped on the first cycle after the controller's busy flag is seen, so each click issues exactly one transaction.

While reset is held, the read and write addresses are loaded from the switches, with the 4-bit value repeated across the full address width. They keep that value until the next reset. On a write commit, the switch value is repeated across the data bus. Read data is captured on the controller's ready pulse and held. Its two bytes take turns on the LEDs, swapping on a programmable period. The gap window and the swap period are parameters, so that simulation can use short values.

Top module: `btn_mem_exerciser`

## Requirements
- R1: While `rstN` is low, `wrEnable` and `rdEnable` are low on the next clock. After reset, the held read result is zero and `ledOut` shows 0.
- R2: Every clock edge with `rstN` low loads `wrAddr` and `rdAddr` with the switch value repeated, so that bit i equals `dipSw[i mod 4]`. After `rstN` rises, both addresses stay unchanged whatever the switches do.
- R3: A press and release with no further press within CLICK_WIN cycles after the release gives exactly one write request. No write request appears before the window runs out. `wrData` carries the switch value repeated across the 16 bits, taken when the click is committed, and `wrAddr` is the reset-loaded address.
- R4: A second press that arrives within the window after the first release gives exactly one read request and no write request. A second press that arrives after the window has expired is treated as a new click, so two slow clicks give two writes.
- R5: An enable that is high while `busy` is sampled high goes low on the next clock. `wrEnable` and `rdEnable` are never high together. Each click issues only one request.
- R6: `rdData` is captured on the clock where `rdReady` is high. The captured word is held unchanged until the next `rdReady`, even when writes happen in between.
- R7: `ledOut` alternates between bits [7:0] and bits [15:8] of the held read word, swapping every LED_PERIOD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; also loads the addresses from the switches |
| buttonRaw | input | 1 | Asynchronous push button, high when pressed |
| dipSw | input | 4 | Switch value for the addresses and the write data |
| wrAddr | output | ADDR_W | Write address to the controller |
| wrData | output | DATA_W | Write data to the controller |
| wrEnable | output | 1 | Write request, held until busy is seen |
| rdAddr | output | ADDR_W | Read address to the controller |
| rdEnable | output | 1 | Read request, held until busy is seen |
| rdData | input | DATA_W | Read data from the controller |
| rdReady | input | 1 | One-cycle strobe qualifying rdData |
| busy | input | 1 | Controller is working on a request |
| ledOut | output | DATA_W/2 | Byte of the held read word currently on display |

## Verification
A button edge takes three clocks to reach the click logic: two synchroniser flops and one edge flop. A single click therefore commits about CLICK_WIN+4 cycles after the release. The bench checks that no request exists CLICK_WIN-5 cycles after the release and that exactly one exists CLICK_WIN+30 cycles after it, so neither check sits on the boundary. A monitor samples on the falling edge and requires each enable to be low one cycle after busy was seen high. The LED check first waits for a byte swap, then measures three full runs and requires each to last exactly LED_PERIOD cycles and to show the expected byte.

// File: rtl/clickmem_pkg.sv
package clickmem_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;    // reset in progress: capture switch into both addresses
    logic loadWrData;  // single click committed: capture switch into write data
  } dpStrobe_t;

  typedef enum logic [1:0] {
    CK_IDLE,    // waiting for the first press
    CK_FIRST,   // first press held down
    CK_GAP,     // released, window running
    CK_SECOND   // second press held down, waiting for release
  } clickState_t;

  typedef enum logic [1:0] {
    RQ_IDLE,    // no transaction
    RQ_ASK,     // enable raised, waiting for busy
    RQ_WAIT     // busy seen, waiting for it to fall
  } reqState_t;

endpackage

// File: rtl/btn_sync_edge.sv
module btn_sync_edge (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic riseOut,
  output logic fallOut
);
  logic syncA, syncB, lastB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      lastB <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      lastB <= syncB;
    end
  end

  assign riseOut = syncB & ~lastB;
  assign fallOut = ~syncB & lastB;
endmodule

// File: rtl/click_ctrl.sv
module click_ctrl
  import clickmem_pkg::*;
#(
  parameter int CLICK_WIN = 30_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pressRise,
  input  logic      pressFall,
  input  logic      busy,
  output logic      wrEnable,
  output logic      rdEnable,
  output dpStrobe_t strobe
);
  localparam int CNT_W = $clog2(CLICK_WIN + 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(CLICK_WIN - 1);

  clickState_t ckState;
  reqState_t   rqState;
  logic [CNT_W-1:0] gapCnt;
  logic clickSingle, clickDouble, reqIdle;

  // classification of the gap after the first release
  assign clickDouble = (ckState == CK_GAP) && pressRise;
  assign clickSingle = (ckState == CK_GAP) && !pressRise && (gapCnt == GAP_LAST);
  assign reqIdle     = (rqState == RQ_IDLE);

  assign strobe.loadAddr   = !rstN;
  assign strobe.loadWrData = clickSingle && reqIdle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckState <= CK_IDLE;
      gapCnt  <= '0;
    end else begin
      case (ckState)
        CK_IDLE:   if (pressRise) ckState <= CK_FIRST;
        CK_FIRST:  if (pressFall) begin
                     ckState <= CK_GAP;
                     gapCnt  <= '0;
                   end
        CK_GAP:    begin
                     if (pressRise)         ckState <= CK_SECOND;
                     else if (clickSingle)  ckState <= CK_IDLE;
                     else                   gapCnt  <= gapCnt + 1'b1;
                   end
        CK_SECOND: if (pressFall) ckState <= CK_IDLE;
        default:   ckState <= CK_IDLE;
      endcase
    end
  end

  // one transaction per click; clicks landing mid-transaction are dropped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rqState  <= RQ_IDLE;
      wrEnable <= 1'b0;
      rdEnable <= 1'b0;
    end else begin
      case (rqState)
        RQ_IDLE: begin
          if (clickSingle) begin
            wrEnable <= 1'b1;
            rqState  <= RQ_ASK;
          end else if (clickDouble) begin
            rdEnable <= 1'b1;
            rqState  <= RQ_ASK;
          end
        end
        RQ_ASK: if (busy) begin
          wrEnable <= 1'b0;
          rdEnable <= 1'b0;
          rqState  <= RQ_WAIT;
        end
        RQ_WAIT: if (!busy) rqState <= RQ_IDLE;
        default: rqState <= RQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mem_datapath.sv
module mem_datapath
  import clickmem_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int SW_W       = 4,
  parameter int LED_PERIOD = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SW_W-1:0]   dipSw,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] resultHold,
  output logic [DATA_W/2-1:0] ledOut
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LCNT_W = $clog2(LED_PERIOD + 1);
  localparam logic [LCNT_W-1:0] LED_LAST = LCNT_W'(LED_PERIOD - 1);

  logic [ADDR_W-1:0] swAddr;
  logic [DATA_W-1:0] swData;
  logic [LCNT_W-1:0] ledCnt;
  logic              showHigh;

  // repeat the switch nibble across each bus
  for (genvar ai = 0; ai < ADDR_W; ai++) begin : g_addrRep
    assign swAddr[ai] = dipSw[ai % SW_W];
  end
  for (genvar di = 0; di < DATA_W; di++) begin : g_dataRep
    assign swData[di] = dipSw[di % SW_W];
  end

  always_ff @(posedge clk) begin
    if (strobe.loadAddr) begin
      wrAddr <= swAddr;
      rdAddr <= swAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  wrData <= '0;
    else if (strobe.loadWrData) wrData <= swData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        resultHold <= '0;
    else if (rdReady) resultHold <= rdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledCnt   <= '0;
      showHigh <= 1'b0;
    end else if (ledCnt == LED_LAST) begin
      ledCnt   <= '0;
      showHigh <= ~showHigh;
    end else begin
      ledCnt <= ledCnt + 1'b1;
    end
  end

  assign ledOut = showHigh ? resultHold[DATA_W-1 -: HALF_W] : resultHold[HALF_W-1:0];
endmodule

// File: rtl/btn_mem_exerciser.sv
module btn_mem_exerciser
  import clickmem_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int CLICK_WIN  = 30_000_000,
  parameter int LED_PERIOD = 50_000_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                buttonRaw,
  input  logic [3:0]          dipSw,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic                wrEnable,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic                rdEnable,
  input  logic [DATA_W-1:0]   rdData,
  input  logic                rdReady,
  input  logic                busy,
  output logic [DATA_W/2-1:0] ledOut
);
  logic      pressRise, pressFall;
  dpStrobe_t strobe;
  logic [DATA_W-1:0] resultHold;

  btn_sync_edge u_sync (
    .clk(clk), .rstN(rstN), .rawIn(buttonRaw),
    .riseOut(pressRise), .fallOut(pressFall)
  );

  click_ctrl #(.CLICK_WIN(CLICK_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .pressRise(pressRise), .pressFall(pressFall),
    .busy(busy), .wrEnable(wrEnable), .rdEnable(rdEnable), .strobe(strobe)
  );

  mem_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW_W(4), .LED_PERIOD(LED_PERIOD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dipSw(dipSw),
    .rdData(rdData), .rdReady(rdReady), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .resultHold(resultHold), .ledOut(ledOut)
  );
endmodule

// File: rtl/clickmem_checks.sv
module clickmem_checks #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEnable,
  input logic              rdEnable,
  input logic              busy,
  input logic              rdReady,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] resultHold,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!wrEnable && !rdEnable));

  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ($stable(wrAddr) && $stable(rdAddr)));

  a_r4_read_excl: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdEnable) |-> !wrEnable);

  a_r5_wr_drop: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEnable) |=> !wrEnable);

  a_r5_rd_drop: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdEnable) |=> !rdEnable);

  a_r5_not_both: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEnable && rdEnable));

  a_r6_capture: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |=> (resultHold == $past(rdData)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdReady |=> $stable(resultHold));
endmodule

bind btn_mem_exerciser clickmem_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEnable(wrEnable), .rdEnable(rdEnable),
  .busy(busy), .rdReady(rdReady), .rdData(rdData), .resultHold(resultHold),
  .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/btn_mem_exerciser_tb.sv
module btn_mem_exerciser_tb;
  localparam int AW  = 24;
  localparam int DW  = 16;
  localparam int WIN = 40;
  localparam int LP  = 16;
  localparam logic [15:0] RD_TWIST = 16'h5A00;  // stub returns stored ^ this

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic buttonRaw = 1'b0;
  logic [3:0] dipSw = 4'h0;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [DW-1:0] wrData, rdData;
  logic wrEnable, rdEnable, rdReady, busy;
  logic [7:0] ledOut;

  int nChk = 0, nErr = 0;
  int wrReqs = 0, rdReqs = 0, r5Viol = 0;
  logic [AW-1:0] lastWrAddr, lastRdAddr;
  logic [DW-1:0] lastWrData;
  logic [DW-1:0] mem [logic [AW-1:0]];

  always #5 clk = ~clk;

  btn_mem_exerciser #(.ADDR_W(AW), .DATA_W(DW), .CLICK_WIN(WIN), .LED_PERIOD(LP)) u_dut (
    .clk(clk), .rstN(rstN), .buttonRaw(buttonRaw), .dipSw(dipSw),
    .wrAddr(wrAddr), .wrData(wrData), .wrEnable(wrEnable), .rdAddr(rdAddr),
    .rdEnable(rdEnable), .rdData(rdData), .rdReady(rdReady), .busy(busy),
    .ledOut(ledOut)
  );

  // behavioural controller stub: accepts when idle, busy for 5 cycles
  int  stubCnt = 0;
  logic stubRd = 1'b0;
  always @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; rdReady <= 1'b0; rdData <= '0; stubCnt = 0;
    end else begin
      rdReady <= 1'b0;
      if (stubCnt == 0) begin
        if ((wrEnable || rdEnable) && !busy) begin
          busy <= 1'b1; stubCnt = 1; stubRd = rdEnable;
          if (wrEnable) begin
            mem[wrAddr] = wrData; wrReqs++; lastWrAddr = wrAddr; lastWrData = wrData;
          end else begin
            rdReqs++; lastRdAddr = rdAddr;
          end
        end
      end else if (stubCnt == 5) begin
        busy <= 1'b0; stubCnt = 0;
        if (stubRd) begin
          rdReady <= 1'b1;
          rdData  <= (mem.exists(lastRdAddr) ? mem[lastRdAddr] : 16'h0000) ^ RD_TWIST;
        end
      end else stubCnt++;
    end
  end

  // R5 monitor: an enable must be low one cycle after busy was seen
  logic busyPrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && busyPrev && (wrEnable || rdEnable)) r5Viol++;
    if (rstN && wrEnable && rdEnable) r5Viol++;
    busyPrev = busy;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset(input logic [3:0] sw);
    @(negedge clk); dipSw = sw; rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
  endtask

  task automatic pressRelease();
    buttonRaw = 1'b1; waitCyc(5); buttonRaw = 1'b0;
  endtask

  task automatic singleClick(input logic [3:0] sw);
    int w0, r0;
    dipSw = sw; w0 = wrReqs; r0 = rdReqs;
    pressRelease();
    waitCyc(WIN - 5);
    chk("R3 no write before window", 32'(wrReqs), 32'(w0));
    waitCyc(35);
    chk("R3 one write", 32'(wrReqs), 32'(w0 + 1));
    chk("R3 no read", 32'(rdReqs), 32'(r0));
    chk("R3 write data", 32'(lastWrData), 32'({4{sw}}));
    chk("R3 write addr", 32'(lastWrAddr), 32'(wrAddr));
  endtask

  task automatic doubleClick(input int gap, output int dw, output int dr);
    int w0, r0;
    w0 = wrReqs; r0 = rdReqs;
    pressRelease(); waitCyc(gap); pressRelease();
    waitCyc(WIN + 40);
    dw = wrReqs - w0; dr = rdReqs - r0;
  endtask

  // wait for a swap, then time three full runs; each must last LP cycles
  task automatic ledCheck(input string req, input logic [15:0] word);
    logic [7:0] cur;
    int len;
    cur = ledOut; len = 0;
    while (ledOut == cur && len < 3 * LP) begin @(negedge clk); len++; end
    for (int k = 0; k < 3; k++) begin
      cur = ledOut; len = 0;
      while (ledOut == cur && len < 3 * LP) begin @(negedge clk); len++; end
      chk({req, " run length"}, 32'(len), 32'(LP));
      if (cur == word[7:0]) chk({req, " low byte"}, 32'(cur), 32'(word[7:0]));
      else                  chk({req, " high byte"}, 32'(cur), 32'(word[15:8]));
    end
  endtask

  initial begin
    int dw, dr;
    logic [15:0] expWord;
    // R1 / R2: exhaustive sweep of the switch through reset
    for (int s = 0; s < 16; s++) begin
      doReset(4'(s));
      chk("R1 wrEnable low", 32'(wrEnable), 32'd0);
      chk("R1 rdEnable low", 32'(rdEnable), 32'd0);
      chk("R1 led zero", 32'(ledOut), 32'd0);
      chk("R2 wrAddr loaded", 32'(wrAddr), 32'({6{4'(s)}}));
      dipSw = ~4'(s);
      waitCyc(4);
      chk("R2 wrAddr held", 32'(wrAddr), 32'({6{4'(s)}}));
      chk("R2 rdAddr held", 32'(rdAddr), 32'({6{4'(s)}}));
    end
    // R3: single clicks with several switch values
    doReset(4'h9);
    for (int s = 1; s < 16; s += 3) singleClick(4'(s));
    // R4 / R6 / R7: fast double click reads the last write
    singleClick(4'h3);
    doubleClick(10, dw, dr);
    chk("R4 fast double gives read", 32'(dr), 32'd1);
    chk("R4 fast double no write", 32'(dw), 32'd0);
    expWord = {4{4'h3}} ^ RD_TWIST;
    ledCheck("R7 R6", expWord);
    // R6: a later write must not disturb the held word
    singleClick(4'hC);
    ledCheck("R6 hold after write", expWord);
    doubleClick(WIN / 2, dw, dr);
    chk("R4 second read", 32'(dr), 32'd1);
    expWord = {4{4'hC}} ^ RD_TWIST;
    ledCheck("R6 new word", expWord);
    // R4: slow second press is a new click
    dipSw = 4'h6;
    doubleClick(WIN + 20, dw, dr);
    chk("R4 slow double gives two writes", 32'(dw), 32'd2);
    chk("R4 slow double no read", 32'(dr), 32'd0);
    chk("R4 slow data", 32'(lastWrData), 32'(16'h6666));
    // R5: enable dropped after busy, one request per click
    chk("R5 enable drop violations", 32'(r5Viol), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule